// File: doc/BRIEF.md
# Pixel Hit Counter Array with Serial Readout Chain

This block holds one hit counter per pixel of a detector array. While it acquires, every pixel counts the pulses that arrive on its own discriminator line. A single control input then switches the whole array into readout. In readout the twelve flip-flops of each pixel counter stop counting and act as twelve stages of one long serial shift register. That register runs through every pixel, and all counts leave the block on one serial output while new bits enter on one serial input.

The counter flip-flops are the only storage in the block. They have no clear path of their own. A readout that shifts zeros in empties the array, and a readout that shifts a chosen bit stream in preloads every counter with that value. A two-state controller sequences the modes. In state ACQUIRE the counters may count and the shift enable is ignored. In state READOUT the counters may shift and hits are ignored. The transition ACQUIRE→READOUT is taken on the first clock edge that sees the readout select high. The transition READOUT→ACQUIRE is taken on the first clock edge that sees it low. Reset forces ACQUIRE.

The pixel count is set by the row and column parameters. The full array is 64×64. The elaborated default is smaller, and a bench may use a few pixels.

Top module: `pxc_array`

## Requirements
- R1: In acquire mode each rising edge on a pixel's hit input adds exactly one to that pixel's 12-bit count after a two-flop synchroniser. A hit held high for many cycles adds one.
- R2: `readout_i` = 1 selects readout and `readout_i` = 0 selects acquire. The controller state changes on the first clock edge that samples the new value, so a shift request in the cycle the select rises has no effect.
- R3: A count stays at 4095 when further hits arrive. It never wraps.
- R4: In readout, each cycle with `shift_en_i` = 1 moves the chain by one bit. `sdata_o` always shows the MSB of pixel 0. Pixel 0 is read MSB first down to its LSB, then pixel 1, and so on. `sdata_i` enters the LSB of the last pixel.
- R5: Hit edges that occur while the block is in readout, including a rise in readout that is still high after the return to acquire, change no count.
- R6: In acquire mode `shift_en_i` and `sdata_i` have no effect on any count.
- R7: After exactly 12 × pixel-count shifts, each counter holds the 12 bits shifted in for it, in the order of R4. With `sdata_i` held at 0 every counter reads zero afterwards.
- R8: In readout, a cycle with `shift_en_i` = 0 leaves the chain and `sdata_o` unchanged.
- R9: Pixels count independently. Hits on one pixel never change another pixel's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counters, synchronisers and controller |
| rst_n | input | 1 | Active-low reset of controller and synchronisers. Counts are held, not cleared |
| hit_i | input | ROWS*COLS | One discriminator pulse line per pixel, asynchronous |
| readout_i | input | 1 | Mode select: 1 readout, 0 acquire |
| shift_en_i | input | 1 | Advance the chain by one bit (readout only) |
| sdata_i | input | 1 | Serial bit entering the LSB of the last pixel |
| sdata_o | output | 1 | MSB of pixel 0, the head of the chain |

## Verification
The counters are driven with a staircase pattern in which pixel p receives p+1 pulses. Any cross-coupling between neighbours, or any off-by-one in the edge detector, shows up as a wrong count in a known position. A hit held high for many cycles separates edge counting from level counting. A preload just below full scale followed by extra pulses separates saturation from wrap-around. Readouts that write a distinct pattern and read it back, some of them with stall cycles, expose errors in bit order, pixel order and the shift count. Hits and shift requests applied in the wrong mode, and a shift requested in the same cycle the mode select rises, confirm that the controller gates each path.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    // Counter width is fixed by the pixel cell design
    localparam int CNT_W = 12;
    // Flops in the hit synchroniser before edge detection
    localparam int SYNC_STAGES = 2;
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    typedef enum logic {
        PXC_ACQUIRE = 1'b0,
        PXC_READOUT = 1'b1
    } pxc_state_e;
endpackage

// File: rtl/pxc_mode_ctl.sv
module pxc_mode_ctl
    import pxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic readout_i,
    input  logic shift_en_i,
    output logic count_ok_o,
    output logic shift_ok_o
);
    pxc_state_e state_q;
    pxc_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PXC_ACQUIRE: if (readout_i)  state_d = PXC_READOUT;
            PXC_READOUT: if (!readout_i) state_d = PXC_ACQUIRE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PXC_ACQUIRE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the registered state only
    always_comb begin
        count_ok_o = 1'b0;
        shift_ok_o = 1'b0;
        unique case (state_q)
            PXC_ACQUIRE: count_ok_o = 1'b1;
            PXC_READOUT: shift_ok_o = shift_en_i;
        endcase
    end
endmodule

// File: rtl/pxc_hit_edge.sv
module pxc_hit_edge
    import pxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic pulse_o
);
    // stages [SYNC_STAGES-1:0] synchronise, the top stage remembers the last level
    logic [SYNC_STAGES:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[SYNC_STAGES-1:0], hit_i};
    end

    assign pulse_o = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];
endmodule

// File: rtl/pxc_cell.sv
module pxc_cell
    import pxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en,
    input  logic sh_en,
    input  logic ser_in,
    output logic msb_o
);
    // Twelve flops that are either a saturating counter or a shift segment.
    // They have no reset: they hold their value during reset, and readout clears them.
    logic [CNT_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (sh_en)
                q <= {q[CNT_W-2:0], ser_in};
            else if (cnt_en && (q != CNT_FULL))
                q <= q + 1'b1;
        end
    end

    assign msb_o = q[CNT_W-1];
endmodule

// File: rtl/pxc_array.sv
module pxc_array
    import pxc_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int N_PIX = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIX-1:0] hit_i,
    input  logic             readout_i,
    input  logic             shift_en_i,
    input  logic             sdata_i,
    output logic             sdata_o
);
    logic             count_ok;
    logic             shift_ok;
    logic [N_PIX-1:0] pulse;
    logic [N_PIX-1:0] chain_msb;

    pxc_mode_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .readout_i  (readout_i),
        .shift_en_i (shift_en_i),
        .count_ok_o (count_ok),
        .shift_ok_o (shift_ok)
    );

    for (genvar p = 0; p < N_PIX; p++) begin : g_pix
        logic ser_in;

        if (p == N_PIX - 1) begin : g_tail
            assign ser_in = sdata_i;
        end else begin : g_link
            assign ser_in = chain_msb[p+1];
        end

        pxc_hit_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit_i[p]),
            .pulse_o (pulse[p])
        );

        pxc_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_en (pulse[p] & count_ok),
            .sh_en  (shift_ok),
            .ser_in (ser_in),
            .msb_o  (chain_msb[p])
        );
    end

    assign sdata_o = chain_msb[0];
endmodule

// File: rtl/pxc_cell_chk.sv
module pxc_cell_chk
    import pxc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             sh_en,
    input logic             ser_in,
    input logic [CNT_W-1:0] q
);
    // R2: the controller never grants counting and shifting together
    p_mode_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_en && sh_en));

    // R3: a full counter stays full unless the chain shifts
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_en && q == CNT_FULL) |=> (q == CNT_FULL));

    // R1: outside a shift, a count moves by at most one per cycle
    p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> (q == $past(q) || q == $past(q) + 1'b1));

    // R4: a shift drops the serial input into the LSB and moves the rest up
    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |=> (q[0] == $past(ser_in) && q[CNT_W-1:1] == $past(q[CNT_W-2:0])));

    // R8: with neither enable the stage keeps its value
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_en && !cnt_en) |=> $stable(q));
endmodule

bind pxc_cell pxc_cell_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .sh_en  (sh_en),
    .ser_in (ser_in),
    .q      (q)
);

// File: tb/pxc_array_tb.sv
module pxc_array_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 2;
    localparam int COLS = 4;
    localparam int N = ROWS * COLS;

    typedef logic [11:0] vals_t [N];

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hit_i = '0;
    logic         readout_i = 1'b0;
    logic         shift_en_i = 1'b0;
    logic         sdata_i = 1'b0;
    logic         sdata_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxc_array #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .readout_i(readout_i),
        .shift_en_i(shift_en_i), .sdata_i(sdata_i), .sdata_o(sdata_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic rd);
        @(negedge clk);
        readout_i = rd;
        repeat (2) @(negedge clk);
    endtask

    // Full readout (block must be in readout): reads old values, writes new ones.
    // gap=1 inserts a stall cycle after every shift and checks sdata_o holds (R8).
    task automatic xfer(input vals_t wr, output vals_t rd, input bit gap);
        for (int p = 0; p < N; p++) begin
            for (int b = 11; b >= 0; b--) begin
                rd[p][b] = sdata_o;
                sdata_i = wr[p][b];
                shift_en_i = 1'b1;
                @(negedge clk);
                shift_en_i = 1'b0;
                if (gap) begin
                    logic held;
                    held = sdata_o;
                    @(negedge clk);
                    chk("R8 stall holds sdata_o", int'(sdata_o), int'(held));
                end
            end
        end
        shift_en_i = 1'b0;
        sdata_i = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            hit_i = mask;
            repeat (2) @(negedge clk);
            hit_i = '0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic read_and_clear(output vals_t rd);
        vals_t z;
        foreach (z[i]) z[i] = '0;
        set_mode(1'b1);
        xfer(z, rd, 1'b0);
        set_mode(1'b0);
    endtask

    task automatic t_clear();
        vals_t z, rd;
        foreach (z[i]) z[i] = '0;
        set_mode(1'b1);
        xfer(z, rd, 1'b0);
        xfer(z, rd, 1'b0);
        for (int p = 0; p < N; p++) chk("R7 zero after clearing readout", int'(rd[p]), 0);
        set_mode(1'b0);
    endtask

    task automatic t_staircase();
        vals_t rd;
        for (int k = 0; k < N; k++) begin
            logic [N-1:0] m;
            for (int p = 0; p < N; p++) m[p] = (p >= k);
            pulse(m, 1);
        end
        read_and_clear(rd);
        for (int p = 0; p < N; p++) chk("R1/R9 staircase count", int'(rd[p]), p + 1);
    endtask

    task automatic t_hold_high();
        vals_t rd;
        @(negedge clk);
        hit_i = '1;
        repeat (25) @(negedge clk);
        hit_i = '0;
        repeat (4) @(negedge clk);
        read_and_clear(rd);
        for (int p = 0; p < N; p++) chk("R1 held hit counts once", int'(rd[p]), 1);
    endtask

    task automatic t_pattern_gap();
        vals_t wr, rd;
        for (int p = 0; p < N; p++) wr[p] = 12'hA5C ^ 12'(p * 291);
        set_mode(1'b1);
        xfer(wr, rd, 1'b1);
        xfer(wr, rd, 1'b0);
        for (int p = 0; p < N; p++) chk("R4/R7 pattern order", int'(rd[p]), int'(wr[p]));
        set_mode(1'b0);
    endtask

    task automatic t_saturate();
        vals_t wr, rd;
        for (int p = 0; p < N; p++) wr[p] = (p % 2 == 0) ? 12'd4090 : 12'd5;
        set_mode(1'b1);
        xfer(wr, rd, 1'b0);
        set_mode(1'b0);
        pulse('1, 10);
        read_and_clear(rd);
        for (int p = 0; p < N; p++)
            chk("R3 saturation", int'(rd[p]), (p % 2 == 0) ? 4095 : 15);
    endtask

    task automatic t_hits_in_readout();
        vals_t wr, rd;
        for (int p = 0; p < N; p++) wr[p] = 12'(100 + p);
        set_mode(1'b1);
        xfer(wr, rd, 1'b0);
        pulse('1, 3);
        hit_i = '1;
        repeat (4) @(negedge clk);
        set_mode(1'b0);
        repeat (3) @(negedge clk);
        hit_i = '0;
        repeat (4) @(negedge clk);
        read_and_clear(rd);
        for (int p = 0; p < N; p++) chk("R5 hits in readout ignored", int'(rd[p]), 100 + p);
    endtask

    task automatic t_shift_in_acquire();
        vals_t wr, rd;
        for (int p = 0; p < N; p++) wr[p] = 12'(7 * p + 3);
        set_mode(1'b1);
        xfer(wr, rd, 1'b0);
        set_mode(1'b0);
        shift_en_i = 1'b1;
        sdata_i = 1'b1;
        repeat (30) @(negedge clk);
        shift_en_i = 1'b0;
        sdata_i = 1'b0;
        read_and_clear(rd);
        for (int p = 0; p < N; p++) chk("R6 shift ignored in acquire", int'(rd[p]), 7 * p + 3);
    endtask

    task automatic t_mode_latency();
        vals_t wr, rd;
        foreach (wr[i]) wr[i] = '0;
        wr[0] = 12'h800;
        set_mode(1'b1);
        xfer(wr, rd, 1'b0);
        set_mode(1'b0);
        chk("R4 head shows pixel0 MSB", int'(sdata_o), 1);
        // select and shift requested together: first edge only changes state
        readout_i = 1'b1;
        shift_en_i = 1'b1;
        @(negedge clk);
        chk("R2 no shift in select cycle", int'(sdata_o), 1);
        @(negedge clk);
        chk("R2 shift one cycle later", int'(sdata_o), 0);
        shift_en_i = 1'b0;
        repeat (2) @(negedge clk);
        read_and_clear(rd);
        read_and_clear(rd);
        for (int p = 0; p < N; p++) chk("R7 cleared after realign", int'(rd[p]), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_clear();
        t_staircase();
        t_hold_high();
        t_pattern_gap();
        t_saturate();
        t_hits_in_readout();
        t_shift_in_acquire();
        t_mode_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule